// File: doc/BRIEF.md
# UART Status Change Register

This block is the per-channel status word of a serial port. It collects event pulses from the receiver (overrun, break, good non-break frame), level inputs from the transmitter side (free slots in the transmit FIFO, shift register busy) and the clear-to-send pin. It presents them as one 32-bit word on a simple synchronous register port.

Two flags are sticky: overrun and a latched break indicator. Each sets on its event and stays set until software writes a 0 to its bit. Writing a 1 to such a bit leaves it unchanged. A second, live break indicator follows the line state. It sets on a break and clears by itself when the next frame that is not a break completes. The clear-to-send level is synchronized before it is shown. Transmit ready and transmit all-sent are registered views of the transmit path levels.

An interrupt output is the OR of the two sticky flags. The register port has no address or handshake. Reads are continuous on `stat_rdata`, and a write takes effect at the clock edge where `stat_wr` is high. Since the port carries no data stream, it has no valid/ready flow control and never applies back-pressure.

Top module: `ser_stat_reg`

## Requirements
- R1: After reset the word reads 0x0000_0006: overrun (bit 5), CTS (bit 4), live break (bit 3) and sticky break (bit 0) are 0, and transmit ready (bit 2) and all-sent (bit 1) are 1. Bits 31:6 always read 0.
- R2: A pulse on `ev_overrun` sets bit 5 at the next clock edge, and the bit stays 1 while no clearing write occurs.
- R3: A write with `stat_wdata[5]`=0 clears bit 5 at that edge. A write with `stat_wdata[5]`=1 leaves it unchanged.
- R4: A pulse on `ev_break` sets bit 0 at the next edge, and the bit holds until a write with `stat_wdata[0]`=0 clears it. A write with bit 0 = 1 leaves it unchanged.
- R5: When a set event and a clearing write of 0 hit the same sticky bit in the same cycle, the bit ends at 1.
- R6: Bit 3 sets on `ev_break` and clears at the edge after an `ev_frame_ok` pulse that is not accompanied by `ev_break`. If both pulses come together, break wins.
- R7: Bit 4 equals the `cts_pin` level delayed by two clock edges through a two-flop synchronizer. A 1 means high.
- R8: Bit 2 is 1 one edge after `tx_free` is non-zero, and 0 one edge after `tx_free` is zero.
- R9: Bit 1 is 1 one edge after `tx_free` equals FIFO_DEPTH while `tx_shift_busy` is 0, and 0 otherwise.
- R10: `irq` is 1 exactly while bit 5 or bit 0 reads 1.
- R11: Writes have no effect on bits 4, 3, 2, 1 and on bits 31:6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_overrun | input | 1 | One-cycle pulse: receive overrun detected |
| ev_break | input | 1 | One-cycle pulse: break frame detected |
| ev_frame_ok | input | 1 | One-cycle pulse: non-break frame completed |
| cts_pin | input | 1 | Asynchronous clear-to-send pin level |
| tx_free | input | FREE_W (5) | Free entries in the transmit FIFO |
| tx_shift_busy | input | 1 | Transmit shift registers hold data |
| stat_wr | input | 1 | Register write strobe |
| stat_wdata | input | 32 | Register write data |
| stat_rdata | output | 32 | Register read data |
| irq | output | 1 | OR of the sticky flags |

## Verification
The hardest case to reach is a set event landing in the same cycle as a clearing write of 0. Only then does the set-over-clear priority decide the result. The stimulus first sets and clears each sticky flag separately. It then drives `ev_overrun` and `ev_break` on the very same negative edge as a write of all zeros, so both requests are present at one rising edge. A break pulse together with a good-frame pulse covers the matching priority on the live indicator.

// File: rtl/ser_stat_pkg.sv
package ser_stat_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned POS_OVR  = 5;
  localparam int unsigned POS_CTS  = 4;
  localparam int unsigned POS_LBRK = 3;
  localparam int unsigned POS_TRDY = 2;
  localparam int unsigned POS_TALL = 1;
  localparam int unsigned POS_SBRK = 0;
  localparam int unsigned USED_W   = 6;
  localparam int unsigned N_STICKY = 2;
  typedef enum logic [0:0] {STK_OVR = 1'b0, STK_BRK = 1'b1} sticky_e;
endpackage

// File: rtl/ser_stat_sync.sv
module ser_stat_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d_i};
  end
  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/ser_stat_flag.sv
// One status flag with set priority. CLR_ON_ZERO selects whether the
// clear comes from a written 0 (sticky) or from a hardware pulse (live).
module ser_stat_flag #(
  parameter bit CLR_ON_ZERO = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic wbit_i,
  output logic q_o
);
  logic clr_req;
  generate
    if (CLR_ON_ZERO) begin : g_w0c
      assign clr_req = clr_i & ~wbit_i;
    end else begin : g_hw
      logic unused_w;
      assign unused_w = wbit_i;
      assign clr_req  = clr_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_o <= 1'b0;
    else if (set_i)   q_o <= 1'b1;
    else if (clr_req) q_o <= 1'b0;
  end
endmodule

// File: rtl/ser_stat_tx.sv
module ser_stat_tx #(
  parameter int unsigned FIFO_DEPTH = 16,
  localparam int unsigned FREE_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FREE_W-1:0] free_i,
  input  logic              busy_i,
  output logic              ready_o,
  output logic              all_sent_o
);
  localparam logic [FREE_W-1:0] FULL_FREE = FREE_W'(FIFO_DEPTH);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_o    <= 1'b1;
      all_sent_o <= 1'b1;
    end else begin
      ready_o    <= (free_i != '0);
      all_sent_o <= (free_i == FULL_FREE) && !busy_i;
    end
  end
endmodule

// File: rtl/ser_stat_reg.sv
module ser_stat_reg
  import ser_stat_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned FREE_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_overrun,
  input  logic              ev_break,
  input  logic              ev_frame_ok,
  input  logic              cts_pin,
  input  logic [FREE_W-1:0] tx_free,
  input  logic              tx_shift_busy,
  input  logic              stat_wr,
  input  logic [WORD_W-1:0] stat_wdata,
  output logic [WORD_W-1:0] stat_rdata,
  output logic              irq
);
  logic [N_STICKY-1:0] stk_set, stk_wbit, stk_q;
  logic cts_s, live_brk, trdy, tall;

  assign stk_set[STK_OVR]  = ev_overrun;
  assign stk_set[STK_BRK]  = ev_break;
  assign stk_wbit[STK_OVR] = stat_wdata[POS_OVR];
  assign stk_wbit[STK_BRK] = stat_wdata[POS_SBRK];

  // R2 R3 R4 R5: sticky write-zero-to-clear flags
  generate
    for (genvar i = 0; i < N_STICKY; i++) begin : g_stk
      ser_stat_flag #(.CLR_ON_ZERO(1'b1)) u_flag (
        .clk(clk), .rst_n(rst_n), .set_i(stk_set[i]), .clr_i(stat_wr),
        .wbit_i(stk_wbit[i]), .q_o(stk_q[i]));
    end
  endgenerate

  // R6: live break, cleared by a good frame
  ser_stat_flag #(.CLR_ON_ZERO(1'b0)) u_live (
    .clk(clk), .rst_n(rst_n), .set_i(ev_break), .clr_i(ev_frame_ok),
    .wbit_i(1'b0), .q_o(live_brk));

  // R7
  ser_stat_sync #(.STAGES(SYNC_STAGES)) u_cts (
    .clk(clk), .rst_n(rst_n), .d_i(cts_pin), .q_o(cts_s));

  // R8 R9
  ser_stat_tx #(.FIFO_DEPTH(FIFO_DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .free_i(tx_free), .busy_i(tx_shift_busy),
    .ready_o(trdy), .all_sent_o(tall));

  always_comb begin
    stat_rdata           = '0;
    stat_rdata[POS_OVR]  = stk_q[STK_OVR];
    stat_rdata[POS_CTS]  = cts_s;
    stat_rdata[POS_LBRK] = live_brk;
    stat_rdata[POS_TRDY] = trdy;
    stat_rdata[POS_TALL] = tall;
    stat_rdata[POS_SBRK] = stk_q[STK_BRK];
  end

  assign irq = |stk_q;
endmodule

// File: rtl/ser_stat_reg_chk.sv
module ser_stat_reg_chk #(
  parameter int unsigned FREE_W = 5,
  parameter int unsigned FIFO_DEPTH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ev_overrun,
  input logic              ev_break,
  input logic              ev_frame_ok,
  input logic [FREE_W-1:0] tx_free,
  input logic              tx_shift_busy,
  input logic              stat_wr,
  input logic [31:0]       stat_wdata,
  input logic [31:0]       stat_rdata,
  input logic              irq
);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[31:6] == '0);
  a_r2_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overrun |=> stat_rdata[5]);
  a_r3_overrun_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !stat_wdata[5] && !ev_overrun) |=> !stat_rdata[5]);
  a_r3_overrun_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata[5] && !(stat_wr && !stat_wdata[5])) |=> stat_rdata[5]);
  a_r4_break_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rdata[0] && !(stat_wr && !stat_wdata[0])) |=> stat_rdata[0]);
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_break && stat_wr && !stat_wdata[0]) |=> stat_rdata[0]);
  a_r6_live_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_break |=> stat_rdata[3]);
  a_r6_live_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_frame_ok && !ev_break) |=> !stat_rdata[3]);
  a_r8_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (stat_rdata[2] == ($past(tx_free) != '0)));
  a_r9_all_sent: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (stat_rdata[1] ==
      (($past(tx_free) == FREE_W'(FIFO_DEPTH)) && !$past(tx_shift_busy))));
  a_r10_irq_or: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (stat_rdata[5] | stat_rdata[0]));
endmodule

bind ser_stat_reg ser_stat_reg_chk #(.FREE_W(FREE_W), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_overrun(ev_overrun), .ev_break(ev_break),
  .ev_frame_ok(ev_frame_ok), .tx_free(tx_free), .tx_shift_busy(tx_shift_busy),
  .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata), .irq(irq));

// File: tb/test_ser_stat_reg.sv
module test_ser_stat_reg;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned FW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_overrun = 0, ev_break = 0, ev_frame_ok = 0, cts_pin = 0;
  logic [FW-1:0] tx_free = FW'(DEPTH);
  logic tx_shift_busy = 0, stat_wr = 0;
  logic [31:0] stat_wdata = '0;
  logic [31:0] stat_rdata;
  logic irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ser_stat_reg #(.FIFO_DEPTH(DEPTH)) i_ser_stat_reg (
    .clk(clk), .rst_n(rst_n), .ev_overrun(ev_overrun), .ev_break(ev_break),
    .ev_frame_ok(ev_frame_ok), .cts_pin(cts_pin), .tx_free(tx_free),
    .tx_shift_busy(tx_shift_busy), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .stat_rdata(stat_rdata), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // inputs change at the falling edge; one step applies them at the next rising edge
  task automatic step();
    @(posedge clk); @(negedge clk);
    ev_overrun = 0; ev_break = 0; ev_frame_ok = 0; stat_wr = 0; stat_wdata = '0;
  endtask

  task automatic wr(input logic [31:0] d);
    stat_wr = 1; stat_wdata = d; step();
  endtask

  task automatic t_reset();
    chk("R1 reset word", stat_rdata, 32'h6);
    chk("R10 irq reset", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_overrun();
    ev_overrun = 1; step();
    chk("R2 overrun set", {31'd0, stat_rdata[5]}, 1);
    step(); step();
    chk("R2 overrun held", {31'd0, stat_rdata[5]}, 1);
    chk("R10 irq on overrun", {31'd0, irq}, 1);
    wr(32'hFFFF_FFFF);
    chk("R3 write one keeps", stat_rdata, 32'h26);
    wr(32'h0000_0001);
    chk("R3 write zero clears", {31'd0, stat_rdata[5]}, 0);
    chk("R10 irq cleared", {31'd0, irq}, 0);
  endtask

  task automatic t_break();
    ev_break = 1; step();
    chk("R4 R6 break sets both", stat_rdata & 32'h9, 32'h9);
    wr(32'h0000_0000);
    chk("R4 sticky cleared, R11 live kept", stat_rdata & 32'h9, 32'h8);
    ev_frame_ok = 1; step();
    chk("R6 live cleared by frame", {31'd0, stat_rdata[3]}, 0);
    ev_break = 1; ev_frame_ok = 1; step();
    chk("R6 break wins over frame", {31'd0, stat_rdata[3]}, 1);
    wr(32'hFFFF_FFFE);
    chk("R4 write one on others keeps", {31'd0, stat_rdata[0]}, 0);
    ev_frame_ok = 1; step();
  endtask

  task automatic t_collision();
    ev_overrun = 1; ev_break = 1; stat_wr = 1; stat_wdata = '0; step();
    chk("R5 set beats clear", stat_rdata & 32'h21, 32'h21);
    wr(32'h0);
    chk("R5 later clear works", stat_rdata & 32'h21, 32'h0);
    ev_frame_ok = 1; step();
  endtask

  task automatic t_cts();
    cts_pin = 1; step();
    chk("R7 cts after one edge", {31'd0, stat_rdata[4]}, 0);
    step();
    chk("R7 cts after two edges", {31'd0, stat_rdata[4]}, 1);
    cts_pin = 0; step(); step();
    chk("R7 cts low", {31'd0, stat_rdata[4]}, 0);
  endtask

  task automatic t_tx();
    tx_free = FW'(3); step();
    chk("R8 R9 partial fifo", stat_rdata & 32'h6, 32'h4);
    tx_free = '0; step();
    chk("R8 fifo full", stat_rdata & 32'h6, 32'h0);
    tx_free = FW'(DEPTH); tx_shift_busy = 1; step();
    chk("R9 shifter busy", stat_rdata & 32'h6, 32'h4);
    tx_shift_busy = 0; step();
    chk("R9 all sent", stat_rdata & 32'h6, 32'h6);
  endtask

  task automatic t_ro_write();
    cts_pin = 1; ev_break = 1; step(); step();
    wr(32'h0000_0000);
    chk("R11 read-only bits kept on zero write", stat_rdata & 32'h1E, 32'h1E);
    wr(32'hFFFF_FFC0);
    chk("R11 R1 reserved ignore write", stat_rdata, 32'h1E);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_overrun();
    t_break();
    t_collision();
    t_cts();
    t_tx();
    t_ro_write();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule